// File: doc/BRIEF.md
# Alternating Two-Channel Conversion Capture Sequencer

This block sits behind a single shared 8-bit converter that measures two analog quantities in turn: the supply battery level and a user volume setting. The converter's end-of-conversion pulse is the only timing source. Each pulse flips a channel-select flop that steers the external analog multiplexer to the other input for the next conversion. A registered channel flag, always the inverse of the select, tells downstream logic which channel the held result came from.

A delayed copy of the same pulse loads the converter result into a holding register. The register keeps that value until the next capture, which covers a full conversion cycle of about 12 converter clocks. A fixed number of clocks after the delayed pulse, a one-clock valid strobe tells consumers that the held data is settled and can be read. Both measurements share one converter, and no scheduler is needed.

Top module: `tdc_capture_seq`

## Requirements
- R1: While `rst` is high and after it falls, `chan_sel_o` is 0 (battery input selected), `vol_flag_o` is 1, `held_res_o` is 0 and `res_valid_o` is 0.
- R2: A rising edge of `eoc_i` seen at a clock edge flips `chan_sel_o` at that edge. At an edge with no rising `eoc_i`, `chan_sel_o` keeps its value.
- R3: `vol_flag_o` is always the inverse of `chan_sel_o`. A value of 1 marks the held result as the volume channel (select 1) and a value of 0 marks it as the battery channel (select 0).
- R4: `held_res_o` takes the value that `conv_res_i` had during the clock after the `eoc_i` rising edge. With the default delay of one stage, the new value appears one edge after `chan_sel_o` flips.
- R5: Between captures, `held_res_o` does not change, whatever `conv_res_i` does.
- R6: `res_valid_o` is high for exactly one clock. It rises at the eighth edge after the edge that saw the `eoc_i` rising edge (one delay stage plus seven counted clocks).
- R7: If `eoc_i` stays high for several clocks, that counts as one event: one select flip, one capture and one strobe.
- R8: A new event that arrives before a pending strobe has fired cancels that strobe. A single strobe then follows, timed from the newer event.
- R9: Events on a 12-clock cadence make the flag alternate between battery and volume, starting with battery after reset, and each capture comes with its own strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| eoc_i | input | 1 | End-of-conversion from the converter |
| conv_res_i | input | 8 | Converter result, held by the converter after eoc |
| chan_sel_o | output | 1 | Analog mux select, 0 = battery, 1 = volume |
| vol_flag_o | output | 1 | Channel of held result, 1 = volume, 0 = battery |
| held_res_o | output | 8 | Captured result |
| res_valid_o | output | 1 | One-clock strobe: held result may be read |

## Verification
Take the edge that first sees `eoc_i` high as edge zero. The select and flag change at edge zero, the held data at edge one, and the strobe is high only between edges eight and nine. The bench drives inputs on falling edges and samples one falling edge after each of those edges. It confirms the strobe is low at the falling edge before it is due and low again one edge after. For the restart and stretched-pulse cases, it samples the strobe at every falling edge across the window, so an early or doubled strobe is caught.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

  typedef enum logic {
    CH_BATT = 1'b0,
    CH_VOL  = 1'b1
  } chan_e;

  function automatic chan_e other_chan(input chan_e c);
    return (c == CH_BATT) ? CH_VOL : CH_BATT;
  endfunction

endpackage

// File: rtl/tdc_edge_toggle.sv
module tdc_edge_toggle
  import tdc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic eoc_i,
  output logic rise_o,
  output logic sel_o,
  output logic flag_o
);

  logic  eoc_prev_q;
  chan_e sel_q;
  logic  flag_q;

  assign rise_o = eoc_i & ~eoc_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      eoc_prev_q <= 1'b0;
      sel_q      <= CH_BATT;
      flag_q     <= 1'b1;
    end else begin
      eoc_prev_q <= eoc_i;
      if (rise_o) begin
        sel_q  <= other_chan(sel_q);
        flag_q <= (sel_q == CH_VOL);
      end
    end
  end

  assign sel_o  = sel_q;
  assign flag_o = flag_q;

endmodule

// File: rtl/tdc_pulse_delay.sv
module tdc_pulse_delay #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_i,
  output logic pulse_o
);

  localparam int N = (STAGES < 1) ? 1 : STAGES;

  logic [N-1:0] pipe_q;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe_q[0] <= 1'b0;
          else     pipe_q[0] <= pulse_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) pipe_q[g] <= 1'b0;
          else     pipe_q[g] <= pipe_q[g-1];
        end
      end
    end
  endgenerate

  assign pulse_o = pipe_q[N-1];

endmodule

// File: rtl/tdc_hold_reg.sv
module tdc_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);

  logic [DATA_W-1:0] q_q;

  always_ff @(posedge clk) begin
    if (rst)         q_q <= '0;
    else if (load_i) q_q <= d_i;
  end

  assign q_o = q_q;

endmodule

// File: rtl/tdc_valid_timer.sv
module tdc_valid_timer #(
  parameter int VALID_DLY = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic strobe_o
);

  localparam int CNT_W = $clog2(VALID_DLY + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(VALID_DLY);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      if (start_i) begin
        cnt_q <= LOAD;
      end else if (cnt_q == ONE) begin
        cnt_q    <= '0;
        strobe_q <= 1'b1;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  assign strobe_o = strobe_q;

endmodule

// File: rtl/tdc_capture_seq.sv
module tdc_capture_seq #(
  parameter int DATA_W    = 8,
  parameter int EOC_DLY   = 1,
  parameter int VALID_DLY = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eoc_i,
  input  logic [DATA_W-1:0] conv_res_i,
  output logic              chan_sel_o,
  output logic              vol_flag_o,
  output logic [DATA_W-1:0] held_res_o,
  output logic              res_valid_o
);

  logic eoc_rise;
  logic cap_pulse;

  tdc_edge_toggle u_toggle (
    .clk    (clk),
    .rst    (rst),
    .eoc_i  (eoc_i),
    .rise_o (eoc_rise),
    .sel_o  (chan_sel_o),
    .flag_o (vol_flag_o)
  );

  tdc_pulse_delay #(.STAGES(EOC_DLY)) u_dly (
    .clk     (clk),
    .rst     (rst),
    .pulse_i (eoc_rise),
    .pulse_o (cap_pulse)
  );

  tdc_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .load_i (cap_pulse),
    .d_i    (conv_res_i),
    .q_o    (held_res_o)
  );

  tdc_valid_timer #(.VALID_DLY(VALID_DLY)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start_i  (cap_pulse),
    .strobe_o (res_valid_o)
  );

endmodule

// File: rtl/tdc_capture_seq_chk.sv
module tdc_capture_seq_chk #(
  parameter int DATA_W    = 8,
  parameter int VALID_DLY = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              eoc_i,
  input logic [DATA_W-1:0] conv_res_i,
  input logic              chan_sel_o,
  input logic              vol_flag_o,
  input logic [DATA_W-1:0] held_res_o,
  input logic              res_valid_o,
  input logic              cap_pulse
);

  localparam int CW = $clog2(VALID_DLY + 1);

  logic          prev_q;
  logic          rise_c;
  logic [CW-1:0] left_q;
  logic          due_c;

  assign rise_c = eoc_i & ~prev_q;
  assign due_c  = (left_q == CW'(1)) && !cap_pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      left_q <= '0;
    end else begin
      prev_q <= eoc_i;
      if (cap_pulse)         left_q <= CW'(VALID_DLY);
      else if (left_q != '0) left_q <= left_q - CW'(1);
    end
  end

  AST_SEL_FLIP: assert property (@(posedge clk) disable iff (rst)
    rise_c |=> (chan_sel_o != $past(chan_sel_o))); // R2
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rise_c |=> $stable(chan_sel_o)); // R7
  AST_FLAG_INV: assert property (@(posedge clk) disable iff (rst)
    vol_flag_o != chan_sel_o); // R3
  AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    cap_pulse |=> (held_res_o == $past(conv_res_i))); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !cap_pulse |=> $stable(held_res_o)); // R5
  AST_VALID_DUE: assert property (@(posedge clk) disable iff (rst)
    due_c |=> res_valid_o); // R6
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |=> !res_valid_o); // R6
  AST_VALID_ONLY_DUE: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |-> $past(due_c)); // R8

endmodule

bind tdc_capture_seq tdc_capture_seq_chk #(
  .DATA_W    (DATA_W),
  .VALID_DLY (VALID_DLY)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .eoc_i       (eoc_i),
  .conv_res_i  (conv_res_i),
  .chan_sel_o  (chan_sel_o),
  .vol_flag_o  (vol_flag_o),
  .held_res_o  (held_res_o),
  .res_valid_o (res_valid_o),
  .cap_pulse   (cap_pulse)
);

// File: tb/tdc_capture_seq_bench.sv
module tdc_capture_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          eoc = 1'b0;
  logic [DW-1:0] res = '0;
  logic          sel;
  logic          flag;
  logic [DW-1:0] held;
  logic          valid;

  int n_chk  = 0;
  int n_fail = 0;
  logic exp_sel = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdc_capture_seq u_tdc_capture_seq (
    .clk         (clk),
    .rst         (rst),
    .eoc_i       (eoc),
    .conv_res_i  (res),
    .chan_sel_o  (sel),
    .vol_flag_o  (flag),
    .held_res_o  (held),
    .res_valid_o (valid)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Raise eoc for one clock with the given result; return at the falling edge after edge zero.
  task automatic fire(input logic [DW-1:0] v);
    @(negedge clk);
    eoc = 1'b1;
    res = v;
    @(negedge clk);
    eoc = 1'b0;
    exp_sel = ~exp_sel;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(3);
    check("R1 sel in reset", sel, 0);
    check("R1 valid in reset", valid, 0);
    rst = 1'b0;
    exp_sel = 1'b0;
    tick(2);
    check("R1 sel", sel, 0);
    check("R1 flag", flag, 1);
    check("R1 held", held, 0);
    check("R1 valid", valid, 0);
  endtask

  task automatic t_single(input logic [DW-1:0] v);
    fire(v);
    check("R2 sel flips", sel, exp_sel);
    check("R3 flag", flag, !exp_sel);
    tick(1);
    check("R4 held", held, v);
    tick(6);
    check("R6 not early", valid, 0);
    tick(1);
    check("R6 strobe", valid, 1);
    tick(1);
    check("R6 one clock", valid, 0);
  endtask

  task automatic t_hold();
    logic [DW-1:0] keep;
    fire(8'h3C);
    tick(1);
    keep = held;
    res = 8'hC3;
    tick(5);
    check("R5 held stable", held, keep);
    check("R2 sel stable", sel, exp_sel);
    tick(4);
    res = 8'h00;
    tick(2);
    check("R5 held after strobe", held, keep);
  endtask

  task automatic t_stretch();
    int seen = 0;
    @(negedge clk);
    eoc = 1'b1;
    res = 8'h5A;
    @(negedge clk);
    exp_sel = ~exp_sel;
    check("R7 flip once", sel, exp_sel);
    tick(3);
    eoc = 1'b0;
    check("R7 no extra flip", sel, exp_sel);
    for (int i = 0; i < 12; i++) begin
      if (valid) seen++;
      @(negedge clk);
    end
    check("R7 one strobe", seen, 1);
    check("R7 held", held, 8'h5A);
  endtask

  task automatic t_restart();
    int seen = 0;
    fire(8'h11);
    tick(3);
    fire(8'h22);
    // falling edge after new edge zero; strobe due after edge eight
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (i == 8) check("R8 strobe from newer event", valid, 1);
      else        check("R8 no stale strobe", valid, 0);
      if (valid) seen++;
    end
    check("R8 single strobe", seen, 1);
    check("R8 held newer", held, 8'h22);
  endtask

  task automatic t_alternate();
    logic [DW-1:0] vals [4] = '{8'h01, 8'hFE, 8'h80, 8'h7F};
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    exp_sel = 1'b0;
    for (int k = 0; k < 4; k++) begin
      fire(vals[k]);
      check("R9 flag", flag, (k % 2 == 1) ? 1 : 0);
      tick(1);
      check("R9 held", held, vals[k]);
      tick(7);
      check("R9 strobe", valid, 1);
      tick(2);
    end
  endtask

  initial begin
    t_reset();
    t_single(8'hA5);
    t_single(8'h00);
    t_single(8'hFF);
    t_hold();
    t_stretch();
    t_restart();
    t_alternate();
    tick(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule